// File: doc/BRIEF.md
# Longest Prefix Match Forwarding Lookup

This block is a small IPv4 forwarding table with a parallel, mask-based search. A host loads entries through a write port. Each entry holds a 32-bit route prefix, a prefix length, a next-hop address and an output port mask. The host can also drop an entry by clearing its valid flag.

On the lookup side, a destination address comes in with a valid strobe. Every entry compares the address against its own prefix under a per-entry mask built from its length, as a ternary match would. Among the entries that match, the one with the longest prefix wins. The block then returns that entry's next hop and port mask.

If no entry matches, the block reports a miss and flags the packet for software handling. The search runs as two pipeline stages:

- The first stage compares the entries and picks a winner within each fixed group of entries.
- The second stage merges the group winners.

A new lookup can start every cycle.

Top module: `lpm_lookup_top`

## Requirements
- R1: After reset no entry is valid and `res_valid`, `res_hit`, `res_punt`, `res_nexthop` and `res_port` are all zero.
- R2: An entry with prefix P and length y matches address A exactly when bits 31 down to 32-y of A equal the same bits of P. The stored bits of P below that range have no effect.
- R3: An entry of length 0 matches every address, so it acts as a default route.
- R4: When valid entries of different lengths match, the result comes from the entry with the largest length.
- R5: When the longest matching length is shared by several entries, the entry with the lowest index wins.
- R6: On a miss, `res_hit`=0, `res_nexthop`=0, `res_port`=0 and `res_punt`=1.
- R7: A lookup sampled at clock edge E yields `res_valid`=1 only after edge E+1. A lookup may be issued on every edge. In any cycle with no result due, `res_valid` and all result fields are 0.
- R8: A write sampled at edge W is seen by a lookup sampled at edge W+1 or later. A lookup sampled at edge W still sees the table as it was before the write.
- R9: An entry written with `wr_load`=0 (invalidate) never matches afterwards, whatever its old contents were.
- R10: A written length above 32 is stored and used as 32, which means an exact host match.
- R11: On a hit, `res_hit`=1, `res_punt`=0, and `res_nexthop` and `res_port` carry the winning entry's stored values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Table write strobe |
| wr_idx | input | IDX_W (5) | Entry index to write |
| wr_load | input | 1 | 1 = load entry and mark valid, 0 = invalidate entry |
| wr_prefix | input | 32 | Route prefix |
| wr_len | input | 6 | Prefix length, 0..32 (larger values act as 32) |
| wr_nexthop | input | NH_W (32) | Next-hop address |
| wr_port | input | PORT_W (8) | Output port mask |
| lkp_valid | input | 1 | Lookup request strobe |
| lkp_addr | input | 32 | Destination address to look up |
| res_valid | output | 1 | Result present this cycle |
| res_hit | output | 1 | A matching entry was found |
| res_nexthop | output | NH_W (32) | Next hop of the winning entry, 0 on miss |
| res_port | output | PORT_W (8) | Port mask of the winning entry, 0 on miss |
| res_punt | output | 1 | Miss: hand the packet to software |

## Verification
A corrupted valid bit or a wrong stored length in one entry does not show up until a lookup reaches that entry. It then appears two edges later as a wrong next hop, or as a hit where a miss was due, or the reverse.

Priority faults are a different case. They include a reversed tie rule, or a group merge that keeps the wrong winner. These only show when two entries match at once, so the bench builds deliberate overlaps and also sweeps every prefix length on the boundary bits.

A pipeline slip shows on the very next result as `res_valid` landing one cycle early or late. A write-ordering slip shows on a lookup issued on the same edge as the write.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  localparam int ADDR_W  = 32;
  localparam int LEN_W   = 6;
  localparam int MAX_LEN = ADDR_W;

  // lengths beyond the address width collapse to an exact match
  function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] l);
    return (int'(l) > MAX_LEN) ? LEN_W'(MAX_LEN) : l;
  endfunction

  // top l bits set, the rest clear
  function automatic logic [ADDR_W-1:0] len_mask(input logic [LEN_W-1:0] l);
    logic [ADDR_W-1:0] m;
    for (int b = 0; b < ADDR_W; b++) begin
      m[b] = (b >= (ADDR_W - int'(l)));
    end
    return m;
  endfunction

  function automatic logic prefix_covers(input logic [ADDR_W-1:0] addr,
                                         input logic [ADDR_W-1:0] prefix,
                                         input logic [LEN_W-1:0]  l);
    return ((addr ^ prefix) & len_mask(l)) == '0;
  endfunction

endpackage

// File: rtl/lpm_entry_store.sv
module lpm_entry_store
  import lpm_pkg::*;
#(
  parameter int N_ENTRIES = 32,
  parameter int NH_W      = 32,
  parameter int PORT_W    = 8,
  parameter int IDX_W     = $clog2(N_ENTRIES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic                 wr_load,
  input  logic [ADDR_W-1:0]    wr_prefix,
  input  logic [LEN_W-1:0]     wr_len,
  input  logic [NH_W-1:0]      wr_nexthop,
  input  logic [PORT_W-1:0]    wr_port,
  output logic [N_ENTRIES-1:0] ent_valid,
  output logic [ADDR_W-1:0]    ent_prefix [N_ENTRIES],
  output logic [LEN_W-1:0]     ent_len    [N_ENTRIES],
  output logic [NH_W-1:0]      ent_nh     [N_ENTRIES],
  output logic [PORT_W-1:0]    ent_port   [N_ENTRIES]
);

  logic idx_ok;
  logic do_load;
  logic do_kill;

  assign idx_ok  = int'(wr_idx) < N_ENTRIES;
  assign do_load = wr_en && idx_ok && wr_load;
  assign do_kill = wr_en && idx_ok && !wr_load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_valid <= '0;
    end else if (do_load) begin
      ent_valid[wr_idx] <= 1'b1;
    end else if (do_kill) begin
      ent_valid[wr_idx] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (do_load) begin
      ent_prefix[wr_idx] <= wr_prefix;
      ent_len[wr_idx]    <= clamp_len(wr_len);
      ent_nh[wr_idx]     <= wr_nexthop;
      ent_port[wr_idx]   <= wr_port;
    end
  end

  AST_LOAD_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    do_load |=> ent_valid[$past(wr_idx)]); // R8

  AST_KILL_CLEARS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    do_kill |=> !ent_valid[$past(wr_idx)]); // R9

  AST_LEN_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    do_load |=> (int'(ent_len[$past(wr_idx)]) <= MAX_LEN)); // R10

endmodule

// File: rtl/lpm_group_select.sv
module lpm_group_select
  import lpm_pkg::*;
#(
  parameter int GRP_SIZE = 8,
  parameter int NH_W     = 32,
  parameter int PORT_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                lk_valid,
  input  logic [ADDR_W-1:0]   lk_addr,
  input  logic [GRP_SIZE-1:0] ent_valid,
  input  logic [ADDR_W-1:0]   ent_prefix [GRP_SIZE],
  input  logic [LEN_W-1:0]    ent_len    [GRP_SIZE],
  input  logic [NH_W-1:0]     ent_nh     [GRP_SIZE],
  input  logic [PORT_W-1:0]   ent_port   [GRP_SIZE],
  output logic                g_hit,
  output logic [LEN_W-1:0]    g_len,
  output logic [NH_W-1:0]     g_nh,
  output logic [PORT_W-1:0]   g_port
);

  // per-entry ternary compare, brought out for the checks
  logic [GRP_SIZE-1:0] cand_match;

  always_comb begin
    for (int i = 0; i < GRP_SIZE; i++) begin
      cand_match[i] = ent_valid[i] && prefix_covers(lk_addr, ent_prefix[i], ent_len[i]);
    end
  end

  logic              best_found;
  logic [LEN_W-1:0]  best_len;
  logic [NH_W-1:0]   best_nh;
  logic [PORT_W-1:0] best_port;

  // ascending scan, strict compare: lower index keeps a tie
  always_comb begin
    best_found = 1'b0;
    best_len   = '0;
    best_nh    = '0;
    best_port  = '0;
    for (int i = 0; i < GRP_SIZE; i++) begin
      if (cand_match[i] && (!best_found || (ent_len[i] > best_len))) begin
        best_found = 1'b1;
        best_len   = ent_len[i];
        best_nh    = ent_nh[i];
        best_port  = ent_port[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      g_hit  <= 1'b0;
      g_len  <= '0;
      g_nh   <= '0;
      g_port <= '0;
    end else if (lk_valid) begin
      g_hit  <= best_found;
      g_len  <= best_len;
      g_nh   <= best_nh;
      g_port <= best_port;
    end else begin
      g_hit  <= 1'b0;
      g_len  <= '0;
      g_nh   <= '0;
      g_port <= '0;
    end
  end

  AST_GROUP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !g_hit); // R7

  AST_GROUP_NO_CANDIDATE: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && (cand_match == '0)) |=> !g_hit); // R6

  AST_GROUP_HAS_CANDIDATE: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && (cand_match != '0)) |=> g_hit); // R11

endmodule

// File: rtl/lpm_result_merge.sv
module lpm_result_merge
  import lpm_pkg::*;
#(
  parameter int N_GROUPS = 4,
  parameter int NH_W     = 32,
  parameter int PORT_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                s1_valid,
  input  logic [N_GROUPS-1:0] g_hit,
  input  logic [LEN_W-1:0]    g_len  [N_GROUPS],
  input  logic [NH_W-1:0]     g_nh   [N_GROUPS],
  input  logic [PORT_W-1:0]   g_port [N_GROUPS],
  output logic                res_valid,
  output logic                res_hit,
  output logic [NH_W-1:0]     res_nexthop,
  output logic [PORT_W-1:0]   res_port,
  output logic                res_punt
);

  logic              pick_found;
  logic [LEN_W-1:0]  pick_len;
  logic [NH_W-1:0]   pick_nh;
  logic [PORT_W-1:0] pick_port;

  // groups hold ascending index ranges, so strict compare preserves index priority
  always_comb begin
    pick_found = 1'b0;
    pick_len   = '0;
    pick_nh    = '0;
    pick_port  = '0;
    for (int g = 0; g < N_GROUPS; g++) begin
      if (g_hit[g] && (!pick_found || (g_len[g] > pick_len))) begin
        pick_found = 1'b1;
        pick_len   = g_len[g];
        pick_nh    = g_nh[g];
        pick_port  = g_port[g];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid   <= 1'b0;
      res_hit     <= 1'b0;
      res_nexthop <= '0;
      res_port    <= '0;
      res_punt    <= 1'b0;
    end else begin
      res_valid   <= s1_valid;
      res_hit     <= s1_valid && pick_found;
      res_nexthop <= (s1_valid && pick_found) ? pick_nh   : '0;
      res_port    <= (s1_valid && pick_found) ? pick_port : '0;
      res_punt    <= s1_valid && !pick_found;
    end
  end

  AST_MISS_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_hit) |-> ((res_nexthop == '0) && (res_port == '0))); // R6

  AST_PUNT_XOR_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_punt != res_hit)); // R6

  AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (res_hit || res_punt) |-> res_valid); // R7

  AST_IDLE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_valid |=> (!res_valid && (res_nexthop == '0) && (res_port == '0))); // R7

endmodule

// File: rtl/lpm_lookup_top.sv
module lpm_lookup_top
  import lpm_pkg::*;
#(
  parameter int N_ENTRIES = 32,
  parameter int N_GROUPS  = 4,
  parameter int NH_W      = 32,
  parameter int PORT_W    = 8,
  parameter int IDX_W     = $clog2(N_ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_load,
  input  logic [ADDR_W-1:0] wr_prefix,
  input  logic [LEN_W-1:0]  wr_len,
  input  logic [NH_W-1:0]   wr_nexthop,
  input  logic [PORT_W-1:0] wr_port,
  input  logic              lkp_valid,
  input  logic [ADDR_W-1:0] lkp_addr,
  output logic              res_valid,
  output logic              res_hit,
  output logic [NH_W-1:0]   res_nexthop,
  output logic [PORT_W-1:0] res_port,
  output logic              res_punt
);

  // N_ENTRIES must be a multiple of N_GROUPS
  localparam int GRP_SIZE = N_ENTRIES / N_GROUPS;

  logic [N_ENTRIES-1:0] ent_valid;
  logic [ADDR_W-1:0]    ent_prefix [N_ENTRIES];
  logic [LEN_W-1:0]     ent_len    [N_ENTRIES];
  logic [NH_W-1:0]      ent_nh     [N_ENTRIES];
  logic [PORT_W-1:0]    ent_port   [N_ENTRIES];

  lpm_entry_store #(
    .N_ENTRIES(N_ENTRIES), .NH_W(NH_W), .PORT_W(PORT_W), .IDX_W(IDX_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_load(wr_load),
    .wr_prefix(wr_prefix), .wr_len(wr_len),
    .wr_nexthop(wr_nexthop), .wr_port(wr_port),
    .ent_valid(ent_valid), .ent_prefix(ent_prefix), .ent_len(ent_len),
    .ent_nh(ent_nh), .ent_port(ent_port)
  );

  logic s1_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s1_valid <= 1'b0;
    else        s1_valid <= lkp_valid;
  end

  logic [N_GROUPS-1:0] g_hit;
  logic [LEN_W-1:0]    g_len  [N_GROUPS];
  logic [NH_W-1:0]     g_nh   [N_GROUPS];
  logic [PORT_W-1:0]   g_port [N_GROUPS];

  for (genvar g = 0; g < N_GROUPS; g++) begin : gen_grp
    localparam int LO = g * GRP_SIZE;
    localparam int HI = LO + GRP_SIZE - 1;

    lpm_group_select #(
      .GRP_SIZE(GRP_SIZE), .NH_W(NH_W), .PORT_W(PORT_W)
    ) u_grp (
      .clk(clk), .rst_n(rst_n),
      .lk_valid(lkp_valid), .lk_addr(lkp_addr),
      .ent_valid(ent_valid[HI:LO]),
      .ent_prefix(ent_prefix[LO:HI]),
      .ent_len(ent_len[LO:HI]),
      .ent_nh(ent_nh[LO:HI]),
      .ent_port(ent_port[LO:HI]),
      .g_hit(g_hit[g]), .g_len(g_len[g]), .g_nh(g_nh[g]), .g_port(g_port[g])
    );
  end

  lpm_result_merge #(
    .N_GROUPS(N_GROUPS), .NH_W(NH_W), .PORT_W(PORT_W)
  ) u_merge (
    .clk(clk), .rst_n(rst_n),
    .s1_valid(s1_valid),
    .g_hit(g_hit), .g_len(g_len), .g_nh(g_nh), .g_port(g_port),
    .res_valid(res_valid), .res_hit(res_hit),
    .res_nexthop(res_nexthop), .res_port(res_port), .res_punt(res_punt)
  );

  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid == $past(lkp_valid, 2)); // R7

  AST_NO_HIT_ON_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_valid == '0 && lkp_valid) |=> (s1_valid && (g_hit == '0))); // R1

endmodule

// File: tb/lpm_lookup_top_tb_top.sv
module lpm_lookup_top_tb_top;
  import lpm_pkg::*;

  localparam int N      = 32;
  localparam int NH_W   = 32;
  localparam int PORT_W = 8;
  localparam int IDX_W  = 5;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [IDX_W-1:0]  wr_idx = '0;
  logic              wr_load = 1'b0;
  logic [31:0]       wr_prefix = '0;
  logic [5:0]        wr_len = '0;
  logic [NH_W-1:0]   wr_nexthop = '0;
  logic [PORT_W-1:0] wr_port = '0;
  logic              lkp_valid = 1'b0;
  logic [31:0]       lkp_addr = '0;
  logic              res_valid, res_hit, res_punt;
  logic [NH_W-1:0]   res_nexthop;
  logic [PORT_W-1:0] res_port;

  always #4 clk = ~clk;

  lpm_lookup_top #(.N_ENTRIES(N), .N_GROUPS(4), .NH_W(NH_W), .PORT_W(PORT_W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_load(wr_load), .wr_prefix(wr_prefix),
    .wr_len(wr_len), .wr_nexthop(wr_nexthop), .wr_port(wr_port),
    .lkp_valid(lkp_valid), .lkp_addr(lkp_addr),
    .res_valid(res_valid), .res_hit(res_hit), .res_nexthop(res_nexthop),
    .res_port(res_port), .res_punt(res_punt)
  );

  int vectors = 0;
  int fails   = 0;
  bit finished = 0;

  // reference table
  bit          m_v  [N];
  logic [31:0] m_p  [N];
  int          m_l  [N];
  logic [31:0] m_nh [N];
  logic [7:0]  m_pm [N];

  // expectations: e0 issued last tick, e1 due now
  bit e0_v = 0, e1_v = 0, e0_hit = 0, e1_hit = 0;
  logic [31:0] e0_nh = 0, e1_nh = 0;
  logic [7:0]  e0_pm = 0, e1_pm = 0;
  string e0_tag = "", e1_tag = "";

  logic [31:0] rs = 32'h1234_5678;

  function automatic logic [31:0] ip(input int a, input int b, input int c, input int d);
    return {a[7:0], b[7:0], c[7:0], d[7:0]};
  endfunction

  function automatic logic [31:0] nxt();
    rs ^= rs << 13;
    rs ^= rs >> 17;
    rs ^= rs << 5;
    return rs;
  endfunction

  // scan downward, keep on >=: the last kept is the lowest index among the longest
  task automatic model_expect(input logic [31:0] a, output bit hit,
                              output logic [31:0] nh, output logic [7:0] pm);
    int bl;
    bl = -1; hit = 0; nh = 0; pm = 0;
    for (int i = N - 1; i >= 0; i--) begin
      logic [31:0] msk;
      if (m_v[i]) begin
        msk = (m_l[i] == 0) ? 32'h0 : ~((32'h1 << (32 - m_l[i])) - 32'h1);
        if ((((a ^ m_p[i]) & msk) == 32'h0) && (m_l[i] >= bl)) begin
          bl = m_l[i]; hit = 1; nh = m_nh[i]; pm = m_pm[i];
        end
      end
    end
  endtask

  task automatic check_out();
    bit pv;
    vectors++;
    pv = e1_v && !e1_hit;
    if (res_valid !== e1_v || res_hit !== (e1_v && e1_hit) || res_punt !== pv ||
        res_nexthop !== (e1_v && e1_hit ? e1_nh : 32'h0) ||
        res_port !== (e1_v && e1_hit ? e1_pm : 8'h0)) begin
      fails++;
      $display("FAIL %s: valid/hit/punt/nh/port got %0b/%0b/%0b/%h/%h expected %0b/%0b/%0b/%h/%h",
               e1_v ? e1_tag : "R7 idle", res_valid, res_hit, res_punt, res_nexthop, res_port,
               e1_v, e1_v && e1_hit, pv, e1_v && e1_hit ? e1_nh : 32'h0,
               e1_v && e1_hit ? e1_pm : 8'h0);
    end
  endtask

  // called at a negedge; returns at the next negedge
  task automatic tick(input bit wr, input int idx, input bit load, input logic [31:0] pfx,
                      input int len, input logic [31:0] nh, input logic [7:0] pm,
                      input bit lk, input logic [31:0] addr, input string tag);
    bit h; logic [31:0] enh; logic [7:0] epm;
    check_out();
    e1_v = e0_v; e1_hit = e0_hit; e1_nh = e0_nh; e1_pm = e0_pm; e1_tag = e0_tag;
    wr_en = wr; wr_idx = IDX_W'(idx); wr_load = load; wr_prefix = pfx;
    wr_len = 6'(len); wr_nexthop = nh; wr_port = pm;
    lkp_valid = lk; lkp_addr = addr;
    if (lk) begin
      model_expect(addr, h, enh, epm);
      e0_v = 1; e0_hit = h; e0_nh = enh; e0_pm = epm; e0_tag = tag;
    end else begin
      e0_v = 0; e0_hit = 0; e0_nh = 0; e0_pm = 0; e0_tag = "";
    end
    if (wr && idx < N) begin
      m_v[idx] = load;
      if (load) begin
        m_p[idx] = pfx; m_l[idx] = (len > 32) ? 32 : len; m_nh[idx] = nh; m_pm[idx] = pm;
      end
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic put(input int idx, input logic [31:0] pfx, input int len,
                     input logic [31:0] nh, input logic [7:0] pm);
    tick(1, idx, 1, pfx, len, nh, pm, 0, 0, "");
  endtask

  task automatic kill(input int idx);
    tick(1, idx, 0, 0, 0, 0, 0, 0, 0, "");
  endtask

  task automatic look(input logic [31:0] a, input string tag);
    tick(0, 0, 0, 0, 0, 0, 0, 1, a, tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(0, 0, 0, 0, 0, 0, 0, 0, 0, "");
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin
      m_v[i] = 0; m_p[i] = 0; m_l[i] = 0; m_nh[i] = 0; m_pm[i] = 0;
    end
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    vectors++;
    if (res_valid !== 0 || res_hit !== 0 || res_punt !== 0 || res_nexthop !== 0 || res_port !== 0) begin
      fails++;
      $display("FAIL R1 reset: valid/hit/punt/nh/port got %0b/%0b/%0b/%h/%h expected 0/0/0/0/0",
               res_valid, res_hit, res_punt, res_nexthop, res_port);
    end
    rst_n = 1'b1;
    @(negedge clk);

    look(ip(10,0,0,1), "R1 empty table miss");
    put(5, ip(128,9,0,0), 16, 32'hAAAA_0005, 8'h01);
    put(9, ip(128,9,16,0), 20, 32'hBBBB_0009, 8'h02);
    look(ip(128,9,16,14), "R4 longest wins");
    look(ip(128,9,200,1), "R11 hit data");
    look(ip(128,9,0,0), "R2 low end of range");
    look(ip(128,9,255,255), "R2 high end of range");
    look(ip(128,10,0,0), "R6 miss");
    put(31, ip(77,77,77,77), 0, 32'hDDDD_001F, 8'h80);
    look(ip(10,0,0,1), "R3 default route");
    look(ip(128,9,16,14), "R4 longer beats default");
    put(7, ip(10,0,0,0), 8, 32'hCCCC_0007, 8'h04);
    put(2, ip(10,0,0,0), 8, 32'hCCCC_0002, 8'h08);
    look(ip(10,1,2,3), "R5 tie lower index");
    put(12, ip(192,168,1,77), 24, 32'hEEEE_000C, 8'h10);
    look(ip(192,168,1,5), "R2 stored host bits ignored");
    put(20, ip(172,16,5,9), 45, 32'hFFFF_0014, 8'h20);
    look(ip(172,16,5,9), "R10 clamped exact match");
    look(ip(172,16,5,8), "R10 neighbour falls to default");
    kill(9);
    look(ip(128,9,16,14), "R9 invalidated entry skipped");
    kill(31);
    look(ip(11,0,0,1), "R9 default removed gives miss");
    tick(1, 9, 1, ip(128,9,16,0), 20, 32'hBBBB_0009, 8'h02, 1, ip(128,9,16,14), "R8 same edge sees old");
    look(ip(128,9,16,14), "R8 next edge sees new");
    idle(2);

    // R2 sweep over every length with boundary bits
    for (int i = 0; i < N; i++) kill(i);
    for (int y = 0; y <= 32; y++) begin
      logic [31:0] p;
      p = 32'hA5C3_0F96;
      put(0, p, y, 32'h100 + y, 8'(y));
      look(p, "R2 sweep exact");
      if (y < 32) look(p ^ (32'h1 << (31 - y)), "R2 sweep first host bit");
      if (y > 0)  look(p ^ (32'h1 << (32 - y)), "R2 sweep last prefix bit");
    end

    // R4 R5 R8 R9 mixed random traffic
    for (int i = 0; i < N; i++) begin
      logic [31:0] r;
      r = nxt();
      put(i, {8'h0A, 6'b0, r[17:0]}, int'(r[29:24]) % 40, nxt(), r[7:0]);
    end
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] r, a;
      r = nxt(); a = nxt();
      if (r[2:0] == 3'd0)
        tick(1, int'(r[12:8]), r[3] | r[4], {8'h0A, 6'b0, a[31:14]}, int'(r[21:16]) % 40,
             nxt(), r[31:24], r[5], {8'h0A, 6'b0, a[17:0]}, "R4 R5 R8 random");
      else
        tick(0, 0, 0, 0, 0, 0, 0, r[6] | r[7], {8'h0A, 6'b0, a[17:0]}, "R4 R5 R9 random");
    end
    idle(3);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R7 watchdog: cycles got 100000 expected fewer");
      finish_run();
    end
  end

endmodule